// File: doc/BRIEF.md
# Run-Time Selectable Significand Rounder

This block takes an unrounded floating-point value and rounds it to one of three result widths, all handled by a single shared datapath. The value is given as a sign, a 64-bit significand with the integer bit at bit 63, a 15-bit biased exponent, and an input sticky bit. The input sticky bit stands for nonzero bits that lie below bit 0 of the significand. A 16-bit control word selects the result width and the rounding direction. The same control word carries a mask for the precision (inexact) exception.

The result is registered with one cycle of latency. The register captures a new result only when `in_valid` is high, and `out_valid` marks the cycle in which a fresh result is present. If rounding carries out of the top of the significand, the block renormalises the value and adjusts the exponent in that same cycle. It reports inexactness in two forms: a raw flag, and an exception request that the mask gates.

Top module: `fpr_rounder`

## Requirements
- R1: Control word bits [9:8] select the kept significand width: 00 keeps 24 bits, 10 keeps 53 bits, and 01 (reserved) or 11 keeps 64 bits. The kept bits are the top bits of `out_sig`, and every bit below them reads zero. Control word bits other than 5 and 11:8 have no effect.
- R2: Control word bits [11:10] = 00 rounds to nearest, with ties going to the even result. The guard bit is the first bit below the kept field, the round bit is the next one down, and the sticky is the OR of all lower bits and `in_sticky`. At 64-bit width only `in_sticky` lies below the kept field, so it counts as sticky with guard = 0.
- R3: Code 01 rounds toward negative infinity: the magnitude is incremented by one unit in the last place exactly when the value is inexact and `in_sign` = 1.
- R4: Code 10 rounds toward positive infinity: the magnitude is incremented exactly when the value is inexact and `in_sign` = 0.
- R5: Code 11 truncates toward zero: the magnitude is never incremented.
- R6: When the increment carries out of bit 63, `out_sig` becomes 0x8000_0000_0000_0000 and `out_exp` becomes `in_exp` + 1, modulo 2^15. In every other case `out_exp` equals `in_exp`, and `out_sign` always equals `in_sign`.
- R7: `out_inexact` is 1 exactly when any discarded bit or `in_sticky` is nonzero, whatever the mask setting.
- R8: `out_exc_req` equals `out_inexact` AND NOT control word bit 5 (the precision mask).
- R9: Results appear one clock after `in_valid` is high, and `out_valid` is high in that cycle. When `in_valid` is low, the next cycle has `out_valid` = 0 and all data outputs hold their previous values.
- R10: While `rst_n` is low, every output is zero. Reset asserts asynchronously and is released on a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input value is present this cycle |
| in_sign | input | 1 | Sign of the value |
| in_sig | input | 64 | Unrounded significand, integer bit at 63 |
| in_exp | input | 15 | Biased exponent |
| in_sticky | input | 1 | OR of bits below significand bit 0 |
| in_ctrl | input | 16 | Control word: bit 5 mask, [9:8] width, [11:10] direction |
| out_valid | output | 1 | Result registered from the previous cycle |
| out_sign | output | 1 | Sign of the result |
| out_sig | output | 64 | Rounded significand |
| out_exp | output | 15 | Exponent after renormalisation |
| out_inexact | output | 1 | Discarded bits were nonzero |
| out_exc_req | output | 1 | Unmasked precision exception request |

## Verification
A carry-out renormalisation and a masked inexact result can both happen in one cycle. The bench provokes this with a 24-bit all-ones significand whose discarded part is an exact tie, rounded to nearest with the mask set. In that cycle it expects the significand to read 0x8000_0000_0000_0000 and the exponent to have gone up by one. It also expects `out_inexact` high and `out_exc_req` low. A second vector drives a carry together with an exponent of 0x7FFF, so the exponent wrap and the exception request are checked in the same result.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

  localparam int CTRL_W      = 16;
  localparam int CTRL_MASK_B = 5;
  localparam int CTRL_PC_LO  = 8;
  localparam int CTRL_RC_LO  = 10;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'b00,
    RND_DOWN    = 2'b01,
    RND_UP      = 2'b10,
    RND_ZERO    = 2'b11
  } rnd_mode_e;

  typedef enum logic [1:0] {
    PSEL_NARROW = 2'd0,
    PSEL_MID    = 2'd1,
    PSEL_WIDE   = 2'd2
  } prec_idx_e;

  localparam int N_PREC = 3;

  typedef struct packed {
    logic lsb;
    logic guard;
    logic round;
    logic sticky;
  } grs_t;

endpackage

// File: rtl/fpr_ctrl_decode.sv
module fpr_ctrl_decode
  import fpr_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl,
  output prec_idx_e         prec_idx,
  output rnd_mode_e         rnd_mode,
  output logic              inx_mask
);

  logic [1:0] pc_code;

  assign pc_code  = ctrl[CTRL_PC_LO +: 2];
  assign rnd_mode = rnd_mode_e'(ctrl[CTRL_RC_LO +: 2]);
  assign inx_mask = ctrl[CTRL_MASK_B];

  always_comb begin
    unique case (pc_code)
      2'b00:   prec_idx = PSEL_NARROW;
      2'b10:   prec_idx = PSEL_MID;
      default: prec_idx = PSEL_WIDE;
    endcase
  end

endmodule

// File: rtl/fpr_grs_tap.sv
module fpr_grs_tap
  import fpr_pkg::*;
#(
  parameter int SIG_W = 64,
  parameter int KEEP  = 24
) (
  input  logic [SIG_W-1:0] sig,
  input  logic             sticky_in,
  output grs_t             grs,
  output logic [SIG_W-1:0] keep_mask,
  output logic [SIG_W-1:0] ulp
);

  localparam int DROP = SIG_W - KEEP;
  localparam logic [SIG_W-1:0] ONE = SIG_W'(1);

  assign ulp       = ONE << DROP;
  assign keep_mask = ~(ulp - ONE);
  assign grs.lsb   = sig[DROP];

  generate
    if (DROP == 0) begin : g_none
      assign grs.guard  = 1'b0;
      assign grs.round  = 1'b0;
      assign grs.sticky = sticky_in;
    end else if (DROP == 1) begin : g_one
      assign grs.guard  = sig[0];
      assign grs.round  = 1'b0;
      assign grs.sticky = sticky_in;
    end else if (DROP == 2) begin : g_two
      assign grs.guard  = sig[1];
      assign grs.round  = sig[0];
      assign grs.sticky = sticky_in;
    end else begin : g_many
      assign grs.guard  = sig[DROP-1];
      assign grs.round  = sig[DROP-2];
      assign grs.sticky = (|sig[DROP-3:0]) | sticky_in;
    end
  endgenerate

endmodule

// File: rtl/fpr_round_decide.sv
module fpr_round_decide
  import fpr_pkg::*;
(
  input  grs_t      grs,
  input  logic      sign,
  input  rnd_mode_e mode,
  output logic      inc,
  output logic      inexact
);

  always_comb begin
    inexact = grs.guard | grs.round | grs.sticky;
    unique case (mode)
      RND_NEAREST: inc = grs.guard & (grs.round | grs.sticky | grs.lsb);
      RND_DOWN:    inc = inexact & sign;
      RND_UP:      inc = inexact & ~sign;
      default:     inc = 1'b0;
    endcase
  end

endmodule

// File: rtl/fpr_increment.sv
module fpr_increment #(
  parameter int SIG_W = 64,
  parameter int EXP_W = 15
) (
  input  logic [SIG_W-1:0] sig,
  input  logic [SIG_W-1:0] keep_mask,
  input  logic [SIG_W-1:0] ulp,
  input  logic [EXP_W-1:0] exp_in,
  input  logic             inc,
  output logic [SIG_W-1:0] sig_out,
  output logic [EXP_W-1:0] exp_out
);

  logic [SIG_W:0] sum;
  logic [SIG_W:0] addend;

  assign addend = inc ? {1'b0, ulp} : '0;
  assign sum    = {1'b0, sig & keep_mask} + addend;

  always_comb begin
    if (sum[SIG_W]) begin
      sig_out = {1'b1, {(SIG_W-1){1'b0}}};
      exp_out = exp_in + EXP_W'(1);
    end else begin
      sig_out = sum[SIG_W-1:0];
      exp_out = exp_in;
    end
  end

endmodule

// File: rtl/fpr_rounder.sv
module fpr_rounder
  import fpr_pkg::*;
#(
  parameter int SIG_W  = 64,
  parameter int EXP_W  = 15,
  parameter int P_NARR = 24,
  parameter int P_MID  = 53,
  parameter int P_WIDE = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sign,
  input  logic [SIG_W-1:0]  in_sig,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic              in_sticky,
  input  logic [CTRL_W-1:0] in_ctrl,
  output logic              out_valid,
  output logic              out_sign,
  output logic [SIG_W-1:0]  out_sig,
  output logic [EXP_W-1:0]  out_exp,
  output logic              out_inexact,
  output logic              out_exc_req
);

  function automatic int keep_of(input int idx);
    if (idx == 0) return P_NARR;
    else if (idx == 1) return P_MID;
    else return P_WIDE;
  endfunction

  // reset: asynchronous assertion, release aligned to clk
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // control decode
  prec_idx_e prec_idx;
  rnd_mode_e rnd_mode;
  logic      inx_mask;

  fpr_ctrl_decode u_dec (
    .ctrl     (in_ctrl),
    .prec_idx (prec_idx),
    .rnd_mode (rnd_mode),
    .inx_mask (inx_mask)
  );

  // one tap per supported width
  grs_t             grs_v  [N_PREC];
  logic [SIG_W-1:0] mask_v [N_PREC];
  logic [SIG_W-1:0] ulp_v  [N_PREC];

  generate
    for (genvar gi = 0; gi < N_PREC; gi++) begin : g_tap
      fpr_grs_tap #(
        .SIG_W (SIG_W),
        .KEEP  (keep_of(gi))
      ) u_tap (
        .sig       (in_sig),
        .sticky_in (in_sticky),
        .grs       (grs_v[gi]),
        .keep_mask (mask_v[gi]),
        .ulp       (ulp_v[gi])
      );
    end
  endgenerate

  grs_t             grs_sel;
  logic [SIG_W-1:0] mask_sel;
  logic [SIG_W-1:0] ulp_sel;

  always_comb begin
    unique case (prec_idx)
      PSEL_NARROW: begin
        grs_sel = grs_v[0]; mask_sel = mask_v[0]; ulp_sel = ulp_v[0];
      end
      PSEL_MID: begin
        grs_sel = grs_v[1]; mask_sel = mask_v[1]; ulp_sel = ulp_v[1];
      end
      default: begin
        grs_sel = grs_v[2]; mask_sel = mask_v[2]; ulp_sel = ulp_v[2];
      end
    endcase
  end

  logic rnd_inc;
  logic rnd_inexact;

  fpr_round_decide u_decide (
    .grs     (grs_sel),
    .sign    (in_sign),
    .mode    (rnd_mode),
    .inc     (rnd_inc),
    .inexact (rnd_inexact)
  );

  logic [SIG_W-1:0] sum_sig;
  logic [EXP_W-1:0] sum_exp;

  fpr_increment #(
    .SIG_W (SIG_W),
    .EXP_W (EXP_W)
  ) u_inc (
    .sig       (in_sig),
    .keep_mask (mask_sel),
    .ulp       (ulp_sel),
    .exp_in    (in_exp),
    .inc       (rnd_inc),
    .sig_out   (sum_sig),
    .exp_out   (sum_exp)
  );

  // next-state
  logic             nxt_valid;
  logic             nxt_sign;
  logic [SIG_W-1:0] nxt_sig;
  logic [EXP_W-1:0] nxt_exp;
  logic             nxt_inexact;
  logic             nxt_exc_req;
  logic             data_en;

  always_comb begin
    data_en     = in_valid;
    nxt_valid   = in_valid;
    nxt_sign    = in_sign;
    nxt_sig     = sum_sig;
    nxt_exp     = sum_exp;
    nxt_inexact = rnd_inexact;
    nxt_exc_req = rnd_inexact & ~inx_mask;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= nxt_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_sign    <= 1'b0;
      out_sig     <= '0;
      out_exp     <= '0;
      out_inexact <= 1'b0;
      out_exc_req <= 1'b0;
    end else if (data_en) begin
      out_sign    <= nxt_sign;
      out_sig     <= nxt_sig;
      out_exp     <= nxt_exp;
      out_inexact <= nxt_inexact;
      out_exc_req <= nxt_exc_req;
    end
  end

endmodule

// File: rtl/fpr_rounder_chk.sv
module fpr_rounder_chk
  import fpr_pkg::*;
#(
  parameter int SIG_W = 64,
  parameter int EXP_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_sign,
  input logic [SIG_W-1:0]  in_sig,
  input logic              in_sticky,
  input logic [CTRL_W-1:0] in_ctrl,
  input logic              out_valid,
  input logic              out_sign,
  input logic [SIG_W-1:0]  out_sig,
  input logic [EXP_W-1:0]  out_exp,
  input logic              out_inexact,
  input logic              out_exc_req
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_sig) && $stable(out_exp) && $stable(out_inexact)));  // R9

  AST_REQ_NEEDS_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    out_exc_req |-> out_inexact);  // R8

  AST_MASK_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ctrl[CTRL_MASK_B]) |=> !out_exc_req);  // R8

  AST_STAYS_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sig[SIG_W-1]) |=> out_sig[SIG_W-1]);  // R6

  AST_SIGN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_sign == $past(in_sign)));  // R6

  AST_WIDE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ctrl[CTRL_PC_LO] && !in_sticky) |=> (out_sig == $past(in_sig) && !out_inexact));  // R1

endmodule

bind fpr_rounder fpr_rounder_chk #(
  .SIG_W (SIG_W),
  .EXP_W (EXP_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .in_valid    (in_valid),
  .in_sign     (in_sign),
  .in_sig      (in_sig),
  .in_sticky   (in_sticky),
  .in_ctrl     (in_ctrl),
  .out_valid   (out_valid),
  .out_sign    (out_sign),
  .out_sig     (out_sig),
  .out_exp     (out_exp),
  .out_inexact (out_inexact),
  .out_exc_req (out_exc_req)
);

// File: tb/fpr_rounder_bench.sv
`timescale 1ns/1ps
module fpr_rounder_bench;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_sign;
  logic [63:0] in_sig;
  logic [14:0] in_exp;
  logic        in_sticky;
  logic [15:0] in_ctrl;
  logic        out_valid;
  logic        out_sign;
  logic [63:0] out_sig;
  logic [14:0] out_exp;
  logic        out_inexact;
  logic        out_exc_req;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  fpr_rounder u_fpr_rounder (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_sign     (in_sign),
    .in_sig      (in_sig),
    .in_exp      (in_exp),
    .in_sticky   (in_sticky),
    .in_ctrl     (in_ctrl),
    .out_valid   (out_valid),
    .out_sign    (out_sign),
    .out_sig     (out_sig),
    .out_exp     (out_exp),
    .out_inexact (out_inexact),
    .out_exc_req (out_exc_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [63:0] tag;
    logic [15:0] ctrl;
    logic        sign;
    logic        sticky;
    logic [63:0] sig;
    logic [14:0] exp;
    logic [63:0] e_sig;
    logic [14:0] e_exp;
    logic        e_inx;
    logic        e_req;
  } vec_t;

  localparam int NVEC = 15;
  // ctrl: bit5 mask, [9:8] width (00=24,10=53,01/11=64), [11:10] 00 RN,01 down,10 up,11 zero
  localparam vec_t VEC [NVEC] = '{
    '{"R2 R6 R8", 16'h0020, 1'b0, 1'b0, 64'hFFFFFF8000000000, 15'h3FFF, 64'h8000000000000000, 15'h4000, 1'b1, 1'b0},
    '{"R1 R2",    16'hF0DF, 1'b0, 1'b0, 64'h8000008000000000, 15'h3FFF, 64'h8000000000000000, 15'h3FFF, 1'b1, 1'b1},
    '{"R2",       16'h0000, 1'b1, 1'b0, 64'h8000018000000000, 15'h3FFF, 64'h8000020000000000, 15'h3FFF, 1'b1, 1'b1},
    '{"R2 R7",    16'h0000, 1'b0, 1'b0, 64'h8000008000000001, 15'h3FFF, 64'h8000010000000000, 15'h3FFF, 1'b1, 1'b1},
    '{"R5",       16'h0E00, 1'b1, 1'b0, 64'h80000000000007FF, 15'h3FFF, 64'h8000000000000000, 15'h3FFF, 1'b1, 1'b1},
    '{"R4",       16'h0A00, 1'b0, 1'b0, 64'h8000000000000001, 15'h3FFF, 64'h8000000000000800, 15'h3FFF, 1'b1, 1'b1},
    '{"R4",       16'h0A00, 1'b1, 1'b0, 64'h8000000000000001, 15'h3FFF, 64'h8000000000000000, 15'h3FFF, 1'b1, 1'b1},
    '{"R3",       16'h0600, 1'b1, 1'b0, 64'h8000000000000001, 15'h3FFF, 64'h8000000000000800, 15'h3FFF, 1'b1, 1'b1},
    '{"R1 R7",    16'h0300, 1'b0, 1'b0, 64'h123456789ABCDEF0, 15'h3FFF, 64'h123456789ABCDEF0, 15'h3FFF, 1'b0, 1'b0},
    '{"R4 R6",    16'h0B00, 1'b0, 1'b1, 64'hFFFFFFFFFFFFFFFF, 15'h7FFF, 64'h8000000000000000, 15'h0000, 1'b1, 1'b1},
    '{"R1",       16'h0900, 1'b0, 1'b1, 64'h8000000000000000, 15'h3FFF, 64'h8000000000000001, 15'h3FFF, 1'b1, 1'b1},
    '{"R3",       16'h0400, 1'b0, 1'b0, 64'h80000000FFFFFFFF, 15'h3FFF, 64'h8000000000000000, 15'h3FFF, 1'b1, 1'b1},
    '{"R7",       16'h0800, 1'b0, 1'b0, 64'hABCDEF0000000000, 15'h3FFF, 64'hABCDEF0000000000, 15'h3FFF, 1'b0, 1'b0},
    '{"R7 R8",    16'h0220, 1'b0, 1'b1, 64'h8000000000000000, 15'h3FFF, 64'h8000000000000000, 15'h3FFF, 1'b1, 1'b0},
    '{"R2",       16'h0300, 1'b0, 1'b1, 64'hFFFFFFFFFFFFFFFF, 15'h3FFF, 64'hFFFFFFFFFFFFFFFF, 15'h3FFF, 1'b1, 1'b1}
  };

  task automatic check_outs(input string tag, input logic e_valid, input logic e_sign,
                            input logic [63:0] e_sig, input logic [14:0] e_exp,
                            input logic e_inx, input logic e_req);
    checks++;
    if (out_valid !== e_valid || out_sign !== e_sign || out_sig !== e_sig ||
        out_exp !== e_exp || out_inexact !== e_inx || out_exc_req !== e_req) begin
      failures++;
      $display("FAIL %s: got v=%b s=%b sig=%h exp=%h inx=%b req=%b expected v=%b s=%b sig=%h exp=%h inx=%b req=%b",
               tag, out_valid, out_sign, out_sig, out_exp, out_inexact, out_exc_req,
               e_valid, e_sign, e_sig, e_exp, e_inx, e_req);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_sign   = 1'b0;
    in_sig    = '0;
    in_exp    = '0;
    in_sticky = 1'b0;
    in_ctrl   = '0;
    repeat (3) @(negedge clk);
    // R10: outputs zero while reset is held
    check_outs("R10 reset", 1'b0, 1'b0, 64'h0, 15'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_outs("R10 after release", 1'b0, 1'b0, 64'h0, 15'h0, 1'b0, 1'b0);

    // table walk, one result per vector one cycle later (R9)
    for (int i = 0; i < NVEC; i++) begin
      in_valid  = 1'b1;
      in_ctrl   = VEC[i].ctrl;
      in_sign   = VEC[i].sign;
      in_sticky = VEC[i].sticky;
      in_sig    = VEC[i].sig;
      in_exp    = VEC[i].exp;
      @(negedge clk);
      check_outs($sformatf("%s R9 vec%0d", VEC[i].tag, i), 1'b1, VEC[i].sign,
                 VEC[i].e_sig, VEC[i].e_exp, VEC[i].e_inx, VEC[i].e_req);
    end

    // R9: idle input leaves the last result in place
    in_valid  = 1'b0;
    in_sig    = 64'h8000008000000001;
    in_sign   = 1'b1;
    in_ctrl   = 16'h0000;
    @(negedge clk);
    check_outs("R9 hold", 1'b0, 1'b0, 64'hFFFFFFFFFFFFFFFF, 15'h3FFF, 1'b1, 1'b1);
    @(negedge clk);
    check_outs("R9 hold2", 1'b0, 1'b0, 64'hFFFFFFFFFFFFFFFF, 15'h3FFF, 1'b1, 1'b1);

    // R6 with R8: carry and masked inexact again, then back-to-back unmasked
    in_valid  = 1'b1;
    in_sign   = 1'b1;
    in_sticky = 1'b0;
    in_sig    = 64'hFFFFFF8000000000;
    in_exp    = 15'h0001;
    in_ctrl   = 16'h0020;
    @(negedge clk);
    check_outs("R6 R8 carry masked", 1'b1, 1'b1, 64'h8000000000000000, 15'h0002, 1'b1, 1'b0);
    in_ctrl = 16'h0000;
    @(negedge clk);
    check_outs("R6 R8 carry unmasked", 1'b1, 1'b1, 64'h8000000000000000, 15'h0002, 1'b1, 1'b1);
    in_valid = 1'b0;

    // R10: asynchronous reset mid-run clears the outputs
    @(posedge clk);
    #1 rst_n = 1'b0;
    #1;
    check_outs("R10 async", 1'b0, 1'b0, 64'h0, 15'h0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule